// File: doc/BRIEF.md
# Interrupt Cause Register Bank

This block gathers up to 32 single-cycle event pulses into a sticky cause register. It drives one level interrupt line that is high while any pending cause is unmasked. A small register-mapped host port (address, write enable, write data, read enable, read data) gives software access to the cause bits, a mask, and a per-bit clear-mode selection.

Software changes the mask through two write-only registers. One sets the mask bits that are 1 in the written pattern, and the other clears them. A third register reads the current mask back. The clear-mode register decides, bit by bit, how a pending cause is acknowledged. A mode bit of 1 makes that cause clear when the cause register is read. A mode bit of 0 makes it clear only when software writes 1 to it.

The interrupt line comes from a two-state machine with the states `IRQ_IDLE` and `IRQ_PEND`. The transition `IRQ_IDLE -> IRQ_PEND` is taken when any cause bit is set and unmasked. The transition `IRQ_PEND -> IRQ_IDLE` is taken when no such bit remains. The line is high exactly in `IRQ_PEND`.

Top module: `irq_cause_bank`

## Requirements
- R1: After reset the cause register is 0, every mask bit is 1, every clear-mode bit is 0, and both the read data and the interrupt output are 0.
- R2: Register offsets are cause 0x00, mask-set 0x04, mask-clear 0x08, mask-value 0x0C and clear-mode 0x10. Read data appears in the cycle after the read enable and holds until the next read. A read of any other offset returns 0.
- R3: A 1 on event input i sets cause bit i at the next clock edge, and the bit stays set until it is cleared.
- R4: A write to mask-set ORs the written pattern into the mask, so writing all ones masks every source.
- R5: A write to mask-clear clears only the mask bits that are 1 in the written pattern.
- R6: A read of mask-value returns the current mask and changes no state. Writes to offset 0x0C have no effect.
- R7: A read of the cause register returns the pending bits and clears those whose clear-mode bit is 1. A read leaves bits whose clear-mode bit is 0 set.
- R8: A write to the cause register clears the bits that are 1 in the written pattern and have clear-mode 0. Bits with clear-mode 1 ignore the write.
- R9: An event that arrives in the same cycle as a clear of the same bit, whether by read or by write, wins, and the bit stays set.
- R10: The interrupt output is registered. It equals the OR of (cause AND NOT mask) as it stood one cycle earlier: the state machine enters `IRQ_PEND` when that OR is 1 and returns to `IRQ_IDLE` when it is 0.
- R11: The clear-mode register is written at 0x10 and reads back the value last written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 32 | Event pulses, one per cause bit |
| addr_i | input | 8 | Host register byte offset |
| wr_en_i | input | 1 | Host write strobe |
| wr_data_i | input | 32 | Host write data |
| rd_en_i | input | 1 | Host read strobe |
| rd_data_o | output | 32 | Registered host read data |
| irq_o | output | 1 | Level interrupt output |

## Verification
Some rules are checked on every cycle by the assertions:
- the interrupt line trails the unmasked pending set by exactly one cycle;
- a mask-clear write removes only the written bits;
- a pending event is never lost to a simultaneous clear;
- acknowledged bits are gone one cycle after the acknowledging read or write;
- a mask readback disturbs nothing.

Other behaviour only the bench scenarios can show:
- the reset values;
- the offset decode, including unmapped offsets and the read-only mask-value offset;
- read data holding between reads;
- the difference between the two clear modes on one register.

The bench shows these with hand-computed values and with a behavioural model that is compared on every clock during a long mixed-traffic run.

// File: rtl/icb_pkg.sv
package icb_pkg;

    localparam int unsigned OFS_CAUSE = 32'h00;
    localparam int unsigned OFS_MSET  = 32'h04;
    localparam int unsigned OFS_MCLR  = 32'h08;
    localparam int unsigned OFS_MVAL  = 32'h0C;
    localparam int unsigned OFS_MODE  = 32'h10;

    typedef enum logic [0:0] {
        IRQ_IDLE = 1'b0,
        IRQ_PEND = 1'b1
    } irq_state_e;

    typedef struct packed {
        logic cause_wr;
        logic cause_rd;
        logic mset_wr;
        logic mclr_wr;
        logic mode_wr;
    } strobe_t;

endpackage

// File: rtl/icb_host_port.sv
module icb_host_port
    import icb_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [DATA_W-1:0] cause_q,
    input  logic [DATA_W-1:0] mask_q,
    input  logic [DATA_W-1:0] mode_q,
    output strobe_t           strb_o,
    output logic [DATA_W-1:0] rd_data_o
);

    localparam logic [ADDR_W-1:0] A_CAUSE = ADDR_W'(OFS_CAUSE);
    localparam logic [ADDR_W-1:0] A_MSET  = ADDR_W'(OFS_MSET);
    localparam logic [ADDR_W-1:0] A_MCLR  = ADDR_W'(OFS_MCLR);
    localparam logic [ADDR_W-1:0] A_MVAL  = ADDR_W'(OFS_MVAL);
    localparam logic [ADDR_W-1:0] A_MODE  = ADDR_W'(OFS_MODE);

    logic [DATA_W-1:0] rd_mux;

    // Decode the host strobes; a write to the mask-value offset matches nothing.
    always_comb begin
        strb_o          = '0;
        strb_o.cause_wr = wr_en_i && (addr_i == A_CAUSE);
        strb_o.cause_rd = rd_en_i && (addr_i == A_CAUSE);
        strb_o.mset_wr  = wr_en_i && (addr_i == A_MSET);
        strb_o.mclr_wr  = wr_en_i && (addr_i == A_MCLR);
        strb_o.mode_wr  = wr_en_i && (addr_i == A_MODE);
    end

    always_comb begin
        unique case (addr_i)
            A_CAUSE: rd_mux = cause_q;
            A_MVAL:  rd_mux = mask_q;
            A_MODE:  rd_mux = mode_q;
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data_o <= '0;
        end else if (rd_en_i) begin
            rd_data_o <= rd_mux;
        end
    end

endmodule

// File: rtl/icb_cause_bank.sv
module icb_cause_bank #(
    parameter int unsigned N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt_i,
    input  logic [N-1:0] wr_data_i,
    input  logic         cause_wr_i,
    input  logic         cause_rd_i,
    input  logic [N-1:0] mode_i,
    output logic [N-1:0] cause_q
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        logic ack;

        // Mode 1: acknowledged by a read. Mode 0: acknowledged by writing 1.
        assign ack = mode_i[i] ? cause_rd_i : (cause_wr_i && wr_data_i[i]);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cause_q[i] <= 1'b0;
            end else begin
                cause_q[i] <= evt_i[i] | (cause_q[i] & ~ack);
            end
        end
    end

endmodule

// File: rtl/icb_mask_bank.sv
module icb_mask_bank #(
    parameter int unsigned N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] wr_data_i,
    input  logic         mset_wr_i,
    input  logic         mclr_wr_i,
    input  logic         mode_wr_i,
    output logic [N-1:0] mask_q,
    output logic [N-1:0] mode_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '1;
        end else if (mset_wr_i) begin
            mask_q <= mask_q | wr_data_i;
        end else if (mclr_wr_i) begin
            mask_q <= mask_q & ~wr_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (mode_wr_i) begin
            mode_q <= wr_data_i;
        end
    end

endmodule

// File: rtl/icb_irq_fsm.sv
module icb_irq_fsm
    import icb_pkg::*;
#(
    parameter int unsigned N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] cause_i,
    input  logic [N-1:0] mask_i,
    output logic         irq_o
);

    irq_state_e state_q, state_d;
    logic       pending;

    assign pending = |(cause_i & ~mask_i);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE: if (pending)  state_d = IRQ_PEND;
            IRQ_PEND: if (!pending) state_d = IRQ_IDLE;
            default:  state_d = IRQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IRQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        irq_o = (state_q == IRQ_PEND);
    end

endmodule

// File: rtl/irq_cause_bank.sv
module irq_cause_bank
    import icb_pkg::*;
#(
    parameter int unsigned N      = 32,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      evt_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [N-1:0]      wr_data_i,
    input  logic              rd_en_i,
    output logic [N-1:0]      rd_data_o,
    output logic              irq_o
);

    strobe_t      strb;
    logic [N-1:0] cause_q;
    logic [N-1:0] mask_q;
    logic [N-1:0] mode_q;

    icb_host_port #(.ADDR_W(ADDR_W), .DATA_W(N)) u_host (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_i    (addr_i),
        .wr_en_i   (wr_en_i),
        .rd_en_i   (rd_en_i),
        .cause_q   (cause_q),
        .mask_q    (mask_q),
        .mode_q    (mode_q),
        .strb_o    (strb),
        .rd_data_o (rd_data_o)
    );

    icb_cause_bank #(.N(N)) u_cause (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (evt_i),
        .wr_data_i  (wr_data_i),
        .cause_wr_i (strb.cause_wr),
        .cause_rd_i (strb.cause_rd),
        .mode_i     (mode_q),
        .cause_q    (cause_q)
    );

    icb_mask_bank #(.N(N)) u_mask (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_data_i (wr_data_i),
        .mset_wr_i (strb.mset_wr),
        .mclr_wr_i (strb.mclr_wr),
        .mode_wr_i (strb.mode_wr),
        .mask_q    (mask_q),
        .mode_q    (mode_q)
    );

    icb_irq_fsm #(.N(N)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .cause_i (cause_q),
        .mask_i  (mask_q),
        .irq_o   (irq_o)
    );

endmodule

// File: rtl/irq_cause_bank_chk.sv
module irq_cause_bank_chk
    import icb_pkg::*;
#(
    parameter int unsigned N      = 32,
    parameter int unsigned ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N-1:0]      evt_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic              wr_en_i,
    input logic [N-1:0]      wr_data_i,
    input logic              rd_en_i,
    input logic              irq_o,
    input logic [N-1:0]      cause,
    input logic [N-1:0]      mask,
    input logic [N-1:0]      mode
);

    AST_IRQ_LAGS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == $past(|(cause & ~mask))); // R10

    AST_MASK_CLR_ONLY_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == ADDR_W'(OFS_MCLR)) |=> mask == ($past(mask) & ~$past(wr_data_i))); // R5

    AST_MASK_SET_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == ADDR_W'(OFS_MSET) && wr_data_i == '1) |=> mask == '1); // R4

    AST_EVENT_NOT_LOST: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_i) |=> ($past(evt_i) & ~cause) == '0); // R9

    AST_READ_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && addr_i == ADDR_W'(OFS_CAUSE)) |=> (cause & $past(mode & ~evt_i)) == '0); // R7

    AST_WRITE_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == ADDR_W'(OFS_CAUSE)) |=> (cause & $past(wr_data_i & ~mode & ~evt_i)) == '0); // R8

    AST_MASK_READ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && addr_i == ADDR_W'(OFS_MVAL) && !wr_en_i && evt_i == '0)
        |=> ($stable(cause) && $stable(mask))); // R6

endmodule

bind irq_cause_bank irq_cause_bank_chk #(.N(N), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_i     (evt_i),
    .addr_i    (addr_i),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .rd_en_i   (rd_en_i),
    .irq_o     (irq_o),
    .cause     (cause_q),
    .mask      (mask_q),
    .mode      (mode_q)
);

// File: tb/test_irq_cause_bank.sv
module test_irq_cause_bank;

    localparam int N = 32;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  evt = '0;
    logic [AW-1:0] addr = '0;
    logic          wr_en = 1'b0;
    logic [N-1:0]  wr_data = '0;
    logic          rd_en = 1'b0;
    logic [N-1:0]  rd_data;
    logic          irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // Behavioural reference state.
    logic [N-1:0] m_cause, m_mask, m_mode, m_rd;
    logic         m_irq;

    always #5 clk = ~clk;

    irq_cause_bank #(.N(N), .ADDR_W(AW)) i_irq_cause_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (evt),
        .addr_i    (addr),
        .wr_en_i   (wr_en),
        .wr_data_i (wr_data),
        .rd_en_i   (rd_en),
        .rd_data_o (rd_data),
        .irq_o     (irq)
    );

    always @(posedge clk) begin
        logic [N-1:0] nc;
        if (!rst_n) begin
            m_cause = '0; m_mask = '1; m_mode = '0; m_rd = '0; m_irq = 1'b0;
        end else begin
            m_irq = (m_cause & ~m_mask) != '0;
            if (rd_en) begin
                case (addr)
                    8'h00:   m_rd = m_cause;
                    8'h0C:   m_rd = m_mask;
                    8'h10:   m_rd = m_mode;
                    default: m_rd = '0;
                endcase
            end
            nc = m_cause;
            if (rd_en && addr == 8'h00) nc = nc & ~m_mode;
            if (wr_en && addr == 8'h00) nc = nc & ~(wr_data & ~m_mode);
            nc = nc | evt;
            if (wr_en && addr == 8'h04) m_mask = m_mask | wr_data;
            if (wr_en && addr == 8'h08) m_mask = m_mask & ~wr_data;
            if (wr_en && addr == 8'h10) m_mode = wr_data;
            m_cause = nc;
        end
    end

    // Model comparison on every clock, sampled at the falling edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            n_checks += 2;
            if (rd_data !== m_rd) begin
                n_fail++;
                $display("FAIL R2 model rd_data actual=%08h expected=%08h", rd_data, m_rd);
            end
            if (irq !== m_irq) begin
                n_fail++;
                $display("FAIL R10 model irq actual=%0b expected=%0b", irq, m_irq);
            end
        end
    end

    task automatic cyc(input logic w, input logic r, input logic [AW-1:0] a,
                       input logic [N-1:0] d, input logic [N-1:0] e);
        @(negedge clk);
        wr_en = w; rd_en = r; addr = a; wr_data = d; evt = e;
    endtask

    task automatic idle();
        cyc(1'b0, 1'b0, '0, '0, '0);
    endtask

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic rd_chk(input logic [AW-1:0] a, input logic [N-1:0] exp, input string req);
        cyc(1'b0, 1'b1, a, '0, '0);
        idle();
        check(req, rd_data, exp);
    endtask

    task automatic irq_chk(input logic exp, input string req);
        idle();
        idle();
        check(req, {31'd0, irq}, {31'd0, exp});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 rd_data after reset", rd_data, '0);
        check("R1 irq after reset", {31'd0, irq}, '0);
        rd_chk(8'h0C, 32'hFFFF_FFFF, "R1 mask reset");
        rd_chk(8'h10, 32'h0, "R1 mode reset");
        rd_chk(8'h00, 32'h0, "R1 cause reset");

        // Masked event: sticky, no interrupt.
        cyc(1'b0, 1'b0, '0, '0, 32'h8);
        irq_chk(1'b0, "R4 masked event irq");
        rd_chk(8'h00, 32'h8, "R3 event sticky");
        rd_chk(8'h00, 32'h8, "R7 mode0 survives read");

        // Unmask bit 3.
        cyc(1'b1, 1'b0, 8'h08, 32'h8, '0);
        irq_chk(1'b1, "R10 irq after unmask");
        rd_chk(8'h0C, 32'hFFFF_FFF7, "R5 mask clear one bit");

        // Write-1 acknowledge.
        cyc(1'b1, 1'b0, 8'h00, 32'h8, '0);
        irq_chk(1'b0, "R8 irq drops after w1c");
        rd_chk(8'h00, 32'h0, "R8 cause after w1c");

        // Clear-on-read for bits 7:4.
        cyc(1'b1, 1'b0, 8'h10, 32'hF0, '0);
        rd_chk(8'h10, 32'hF0, "R11 mode readback");
        cyc(1'b0, 1'b0, '0, '0, 32'h20);
        rd_chk(8'h00, 32'h20, "R7 read returns pending");
        rd_chk(8'h00, 32'h0, "R7 read cleared bit");
        cyc(1'b0, 1'b0, '0, '0, 32'h40);
        cyc(1'b1, 1'b0, 8'h00, 32'h40, '0);
        rd_chk(8'h00, 32'h40, "R8 mode1 ignores write");
        rd_chk(8'h00, 32'h0, "R7 mode1 cleared by read");

        // Event racing a clear.
        cyc(1'b0, 1'b0, '0, '0, 32'h8);
        cyc(1'b1, 1'b0, 8'h00, 32'h8, 32'h8);
        rd_chk(8'h00, 32'h8, "R9 event beats w1c");
        cyc(1'b0, 1'b0, '0, '0, 32'h10);
        cyc(1'b0, 1'b1, 8'h00, '0, 32'h10);
        idle();
        check("R7 read with racing event", rd_data, 32'h18);
        rd_chk(8'h00, 32'h18, "R9 event beats read clear");
        rd_chk(8'h00, 32'h8, "R7 racing bit cleared later");

        // Mask everything.
        cyc(1'b1, 1'b0, 8'h04, 32'hFFFF_FFFF, '0);
        irq_chk(1'b0, "R4 mask all drops irq");
        rd_chk(8'h0C, 32'hFFFF_FFFF, "R4 mask all readback");

        // Read-only and unmapped offsets.
        cyc(1'b1, 1'b0, 8'h0C, 32'h0, '0);
        rd_chk(8'h0C, 32'hFFFF_FFFF, "R6 mask-value write ignored");
        rd_chk(8'h00, 32'h8, "R6 mask read left cause");
        rd_chk(8'h14, 32'h0, "R2 unmapped reads zero");
        cyc(1'b0, 1'b1, 8'h0C, '0, '0);
        repeat (3) idle();
        check("R2 read data holds", rd_data, 32'hFFFF_FFFF);

        // Mixed traffic against the model.
        for (int k = 0; k < 600; k++) begin
            logic [AW-1:0] a;
            int sel;
            sel = $urandom_range(0, 5);
            a = AW'(sel * 4);
            cyc(($urandom_range(0, 3) == 0), ($urandom_range(0, 2) == 0), a,
                $urandom(), $urandom() & $urandom() & $urandom());
        end
        repeat (3) idle();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule